// File: doc/BRIEF.md
# Multi-Lane Receive Deskew Release Controller

This block lines up the data of several receive lanes of a serial converter link. Every lane starts delivering words at its own moment, marked by a one-cycle start strobe, and from then on presents one word per clock. Each lane's words collect in a small per-lane elastic buffer. Once every lane has arrived, all buffers are released on the same clock at a common release point. After that the block streams one aligned word per lane per clock, and the first word of every lane appears on the same cycle.

The release point is tied to a free-running multiframe counter supplied from outside, which wraps every `MF_LEN` ticks and comes with a boundary pulse. A release offset register moves the release point earlier than the next boundary by a chosen number of ticks. This trades buffer occupancy against latency. The block also reports the counter value seen when the last lane arrived. An operator can use that value to pick a legal offset.

If a lane would have to hold more words than its buffer has room for before release, the block raises a sticky deskew error and abandons the attempt. A link reset flushes the buffers and starts a new alignment attempt. The error flag is cleared only by reset or by the clear strobe.

Top module: `rx_deskew_release`

## Requirements
- R1: After reset, `out_valid`, `arrival_valid`, `deskew_err`, `last_arrival` and `out_data` are all zero.
- R2: With `rel_offset` equal to 0, the buffers are released on a cycle where `mf_edge` is high. `out_valid` first rises on the following cycle.
- R3: With a nonzero `rel_offset`, release happens on a cycle where `mf_count` equals `MF_LEN - rel_offset`.
- R4: Release requires that every lane's start strobe came on an earlier cycle than the release cycle. A release point that comes sooner, including one on the very cycle of the last start strobe, is skipped, and the next one is used.
- R5: On the cycle after release, each lane's slice of `out_data` (lane n at bits n*DW upward) carries that lane's first word, which is the word presented with its start strobe. Every later cycle carries the next word of that lane, and `out_valid` stays high until a link reset.
- R6: On the cycle when the last lane's start strobe is seen, `mf_count` is captured into `last_arrival`, and `arrival_valid` rises on the next cycle. Both hold until a link reset.
- R7: Each buffer holds `DEPTH` words. A lane that already holds `DEPTH` words and must accept another before release causes `deskew_err` to be set on the next cycle, and that attempt never releases. A lane that holds exactly `DEPTH` words at release raises no error.
- R8: `deskew_err` is sticky. A link reset does not clear it; only reset or `err_clear` does.
- R9: `link_reset` empties the buffers, and on the next cycle `out_valid` and `arrival_valid` read 0, which starts a fresh alignment attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_reset | input | 1 | Flush buffers and restart alignment |
| err_clear | input | 1 | Clears the sticky deskew error |
| lane_start | input | LANES | Per-lane arrival strobe, marks each lane's first word |
| lane_data | input | LANES*DW | Per-lane incoming word, lane n at bits n*DW upward |
| mf_count | input | $clog2(MF_LEN) | Free-running multiframe counter |
| mf_edge | input | 1 | High on the cycle the counter is at the boundary (0) |
| rel_offset | input | $clog2(MF_LEN) | Release offset in ticks before the boundary |
| out_valid | output | 1 | Aligned output words are valid |
| out_data | output | LANES*DW | Aligned words, lane n at bits n*DW upward |
| last_arrival | output | $clog2(MF_LEN) | Counter value when the last lane arrived |
| arrival_valid | output | 1 | `last_arrival` holds a value for this attempt |
| deskew_err | output | 1 | Sticky buffer overrun error |

## Verification
The bench targets three corner cases:
- A last lane whose start strobe lands exactly on a release point. A design that releases on that cycle reads an empty buffer and puts out a misaligned first word; the correct design must wait one full multiframe.
- The depth boundary, tested as two cases. In the first, the earliest lane holds exactly `DEPTH` words at release and must not raise an error. In the second, it holds one word more and must raise one. An off-by-one in the overrun test flips exactly one of these two results.
- A link reset after an error, which must leave `deskew_err` high until `err_clear`. A design that folds the two clears together would lose the flag.

Randomized skews and offsets then cross the release arithmetic with every counter phase.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    typedef enum logic [1:0] {
        ALN_WAIT  = 2'd0,
        ALN_RUN   = 2'd1,
        ALN_FAULT = 2'd2
    } aln_state_e;

    // True on a cycle that is a legal common release point.
    function automatic logic at_release_point(input int unsigned cnt,
                                              input int unsigned off,
                                              input int unsigned mf_len,
                                              input logic        bnd);
        if (off == 0)
            return bnd;
        return (cnt == (mf_len - off));
    endfunction

endpackage

// File: rtl/lane_tracker.sv
module lane_tracker (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic start,
    output logic arrived_q,
    output logic active
);
    always_ff @(posedge clk) begin
        if (rst || flush)
            arrived_q <= 1'b0;
        else if (start)
            arrived_q <= 1'b1;
    end

    // A lane is feeding words from its start cycle on.
    assign active = start | arrived_q;
endmodule

// File: rtl/lane_ebuf.sv
module lane_ebuf #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          overrun
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [DW-1:0]   mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CNTW-1:0] count;
    logic            do_wr, do_rd;

    assign overrun = wr_en && !rd_en && (count == CNTW'(DEPTH));
    assign do_wr   = wr_en && !overrun;
    assign do_rd   = rd_en && (count != '0);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            rd_data <= '0;
        end else begin
            if (do_wr)
                wr_ptr <= bump(wr_ptr);
            if (do_rd) begin
                rd_ptr  <= bump(rd_ptr);
                rd_data <= mem[rd_ptr];
            end
            count <= count + CNTW'(do_wr) - CNTW'(do_rd);
        end
    end
endmodule

// File: rtl/release_fsm.sv
module release_fsm
    import deskew_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int MF_LEN = 8,
    localparam int CW    = $clog2(MF_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_reset,
    input  logic             err_clear,
    input  logic [LANES-1:0] arrived_q,
    input  logic [LANES-1:0] active,
    input  logic [LANES-1:0] lane_ovf,
    input  logic [CW-1:0]    mf_count,
    input  logic             mf_edge,
    input  logic [CW-1:0]    rel_offset,
    output logic             wr_ok,
    output logic             rd_en,
    output logic             out_valid,
    output logic [CW-1:0]    last_arrival,
    output logic             arrival_valid,
    output logic             deskew_err
);
    aln_state_e state, state_nx;
    logic       hit, all_prior, all_now, release_now, any_ovf;

    assign hit         = at_release_point(int'(mf_count), int'(rel_offset), MF_LEN, mf_edge);
    assign all_prior   = &arrived_q;
    assign all_now     = &active;
    assign any_ovf     = |lane_ovf;
    assign release_now = (state == ALN_WAIT) && hit && all_prior && !link_reset;
    assign rd_en       = ((state == ALN_RUN) || release_now) && !link_reset;
    assign wr_ok       = (state != ALN_FAULT);

    always_comb begin
        state_nx = state;
        if (link_reset)
            state_nx = ALN_WAIT;
        else if (state == ALN_WAIT) begin
            if (release_now)
                state_nx = ALN_RUN;
            else if (any_ovf)
                state_nx = ALN_FAULT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ALN_WAIT;
            out_valid <= 1'b0;
        end else begin
            state     <= state_nx;
            out_valid <= rd_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            deskew_err <= 1'b0;
        else if (any_ovf && !link_reset)
            deskew_err <= 1'b1;
        else if (err_clear)
            deskew_err <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arrival_valid <= 1'b0;
            last_arrival  <= '0;
        end else if (link_reset) begin
            arrival_valid <= 1'b0;
        end else if (!arrival_valid && all_now) begin
            arrival_valid <= 1'b1;
            last_arrival  <= mf_count;
        end
    end
endmodule

// File: rtl/rx_deskew_release.sv
module rx_deskew_release
    import deskew_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DW     = 8,
    parameter int DEPTH  = 8,
    parameter int MF_LEN = 8,
    localparam int CW    = $clog2(MF_LEN)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                link_reset,
    input  logic                err_clear,
    input  logic [LANES-1:0]    lane_start,
    input  logic [LANES*DW-1:0] lane_data,
    input  logic [CW-1:0]       mf_count,
    input  logic                mf_edge,
    input  logic [CW-1:0]       rel_offset,
    output logic                out_valid,
    output logic [LANES*DW-1:0] out_data,
    output logic [CW-1:0]       last_arrival,
    output logic                arrival_valid,
    output logic                deskew_err
);
    logic [LANES-1:0] arrived_q, active, lane_ovf;
    logic             wr_ok, rd_en;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_tracker u_trk (
            .clk       (clk),
            .rst       (rst),
            .flush     (link_reset),
            .start     (lane_start[g]),
            .arrived_q (arrived_q[g]),
            .active    (active[g])
        );

        lane_ebuf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
            .clk     (clk),
            .rst     (rst),
            .flush   (link_reset),
            .wr_en   (active[g] && wr_ok && !link_reset),
            .wr_data (lane_data[g*DW +: DW]),
            .rd_en   (rd_en),
            .rd_data (out_data[g*DW +: DW]),
            .overrun (lane_ovf[g])
        );
    end

    release_fsm #(.LANES(LANES), .MF_LEN(MF_LEN)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .link_reset    (link_reset),
        .err_clear     (err_clear),
        .arrived_q     (arrived_q),
        .active        (active),
        .lane_ovf      (lane_ovf),
        .mf_count      (mf_count),
        .mf_edge       (mf_edge),
        .rel_offset    (rel_offset),
        .wr_ok         (wr_ok),
        .rd_en         (rd_en),
        .out_valid     (out_valid),
        .last_arrival  (last_arrival),
        .arrival_valid (arrival_valid),
        .deskew_err    (deskew_err)
    );
endmodule

// File: rtl/rx_deskew_checker.sv
module rx_deskew_checker #(
    parameter int MF_LEN = 8,
    localparam int CW    = $clog2(MF_LEN)
) (
    input logic          clk,
    input logic          rst,
    input logic          link_reset,
    input logic          err_clear,
    input logic [CW-1:0] mf_count,
    input logic          mf_edge,
    input logic [CW-1:0] rel_offset,
    input logic          out_valid,
    input logic [CW-1:0] last_arrival,
    input logic          arrival_valid,
    input logic          deskew_err
);
    // R2 and R3: the stream starts only after a legal release point
    assert_release_point_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |->
            (($past(rel_offset) == '0) ? $past(mf_edge)
                                       : (int'($past(mf_count)) == MF_LEN - int'($past(rel_offset)))));

    assert_arrived_first_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(arrival_valid));

    assert_stream_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !link_reset) |=> out_valid);

    assert_arrival_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (arrival_valid && !link_reset) |=> (arrival_valid && $stable(last_arrival)));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (deskew_err && !err_clear) |=> deskew_err);

    assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
        link_reset |=> (!out_valid && !arrival_valid));
endmodule

bind rx_deskew_release rx_deskew_checker #(.MF_LEN(MF_LEN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .link_reset    (link_reset),
    .err_clear     (err_clear),
    .mf_count      (mf_count),
    .mf_edge       (mf_edge),
    .rel_offset    (rel_offset),
    .out_valid     (out_valid),
    .last_arrival  (last_arrival),
    .arrival_valid (arrival_valid),
    .deskew_err    (deskew_err)
);

// File: tb/sim_rx_deskew_release.sv
module sim_rx_deskew_release;
    localparam int LANES  = 4;
    localparam int DW     = 8;
    localparam int DEPTH  = 8;
    localparam int MF_LEN = 8;
    localparam int CW     = $clog2(MF_LEN);
    localparam int NCYC   = 48;

    logic                clk = 1'b0;
    logic                rst, link_reset, err_clear, mf_edge;
    logic [LANES-1:0]    lane_start;
    logic [LANES*DW-1:0] lane_data;
    logic [CW-1:0]       mf_count, rel_offset;
    logic                out_valid, arrival_valid, deskew_err;
    logic [LANES*DW-1:0] out_data;
    logic [CW-1:0]       last_arrival;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  gcnt     = 0;
    bit  err_prev = 0;
    bit  done     = 0;

    always #4 clk = ~clk;

    rx_deskew_release #(.LANES(LANES), .DW(DW), .DEPTH(DEPTH), .MF_LEN(MF_LEN)) u0 (
        .clk(clk), .rst(rst), .link_reset(link_reset), .err_clear(err_clear),
        .lane_start(lane_start), .lane_data(lane_data), .mf_count(mf_count),
        .mf_edge(mf_edge), .rel_offset(rel_offset), .out_valid(out_valid),
        .out_data(out_data), .last_arrival(last_arrival),
        .arrival_valid(arrival_valid), .deskew_err(deskew_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_hit(input int g0, input int c, input int off);
        int m = (g0 + c) % MF_LEN;
        return (off == 0) ? (m == 0) : (m == MF_LEN - off);
    endfunction

    function automatic int next_hit(input int g0, input int from, input int off);
        for (int c = from; c < from + 2 * MF_LEN; c++)
            if (is_hit(g0, c, off)) return c;
        return -1;
    endfunction

    task automatic drive_mf();
        mf_count = CW'(gcnt % MF_LEN);
        mf_edge  = ((gcnt % MF_LEN) == 0);
        gcnt++;
    endtask

    task automatic run_trial(input int s0, input int s1, input int s2, input int s3,
                             input int off, input bit clr);
        int st[LANES];
        int L, se, t, co, g0, exp_arr;
        bit errcase, exp_err;
        st[0] = s0; st[1] = s1; st[2] = s2; st[3] = s3;
        @(negedge clk);
        link_reset = 1'b1;
        err_clear  = clr;
        lane_start = '0;
        rel_offset = CW'(off);
        drive_mf();
        g0 = gcnt;
        L = st[0]; se = st[0];
        for (int l = 1; l < LANES; l++) begin
            if (st[l] > L)  L  = st[l];
            if (st[l] < se) se = st[l];
        end
        t       = next_hit(g0, L + 1, off);       // R4: strictly after last start
        co      = se + DEPTH;                     // R7: overrun cycle if not released
        errcase = (t > co);
        exp_arr = (g0 + L) % MF_LEN;
        exp_err = clr ? 1'b0 : err_prev;
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            // results of posedge of cycle c-1
            if (errcase && (c - 1 >= co)) exp_err = 1'b1;
            chk(deskew_err == exp_err, "R7/R8 deskew_err", int'(deskew_err), int'(exp_err));
            chk(out_valid == (!errcase && (c - 1 >= t)), "R2/R3/R4/R9 out_valid",
                int'(out_valid), int'(!errcase && (c - 1 >= t)));
            chk(arrival_valid == (c - 1 >= L), "R6/R9 arrival_valid",
                int'(arrival_valid), int'(c - 1 >= L));
            if (c - 1 >= L)
                chk(int'(last_arrival) == exp_arr, "R6 last_arrival", int'(last_arrival), exp_arr);
            if (!errcase && (c - 1 >= t) && out_valid) begin
                for (int l = 0; l < LANES; l++) begin
                    logic [DW-1:0] ew;
                    ew = {2'(l), 6'(c - 1 - t)};
                    chk(out_data[l*DW +: DW] == ew, "R5 aligned word",
                        int'(out_data[l*DW +: DW]), int'(ew));
                end
            end
            link_reset = 1'b0;
            err_clear  = 1'b0;
            for (int l = 0; l < LANES; l++) begin
                lane_start[l] = (c == st[l]);
                lane_data[l*DW +: DW] = (c >= st[l]) ? {2'(l), 6'(c - st[l])} : 8'hEE;
            end
            drive_mf();
        end
        err_prev = exp_err;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed, t;
        seed = $urandom(32'd2024);
        rst = 1'b1; link_reset = 1'b0; err_clear = 1'b0;
        lane_start = '0; lane_data = '0; mf_count = '0; mf_edge = 1'b0; rel_offset = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(arrival_valid == 1'b0, "R1 arrival_valid", int'(arrival_valid), 0);
        chk(deskew_err == 1'b0, "R1 deskew_err", int'(deskew_err), 0);
        chk(out_data == '0, "R1 out_data", int'(out_data), 0);
        chk(last_arrival == '0, "R1 last_arrival", int'(last_arrival), 0);
        rst = 1'b0;

        run_trial(2, 3, 4, 5, 0, 1);                         // R2 boundary release
        run_trial(1, 1, 6, 3, 4, 1);                         // R3 offset release
        t = next_hit(gcnt + 1, 10, 0);
        run_trial(t - 8, t - 1, t - 3, t - 5, 0, 1);         // R7 exactly DEPTH held
        t = next_hit(gcnt + 1, 10, 2);
        run_trial(t - 9, t - 1, t - 2, t - 4, 2, 1);         // R7 one past DEPTH
        run_trial(2, 2, 3, 3, 1, 0);                         // R8 sticky through link reset
        run_trial(2, 2, 3, 3, 1, 1);                         // R8 cleared by err_clear
        t = next_hit(gcnt + 1, 6, 3);
        run_trial(t, t, t, t, 3, 1);                         // R4 postponed release

        for (int k = 0; k < 30; k++) begin
            int b;
            b = 1 + int'($urandom % 3);
            run_trial(b + int'($urandom % 9), b + int'($urandom % 9),
                      b + int'($urandom % 9), b + int'($urandom % 9),
                      int'($urandom % MF_LEN), 1);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule